// File: doc/BRIEF.md
# Carrier-Detect Change Detector

This block watches the carrier-detect lines of the two channels of a dual serial controller. Each raw line is synchronised into the block's clock domain. The settled level is shown on an input-port view with inverted sense: a present carrier reads as 0 and an absent carrier reads as 1. Channel A uses bit 0 and channel B uses bit 1.

Every time a synchronised level differs from its previous sample, the channel's bit is set in a sticky change register and an interrupt request goes high. The host reads the change register with a one-cycle strobe. The read returns the current contents, and on the next cycle the register and the request are cleared. A change that lands in the same cycle as the read is not lost. It stays in the register, so the request goes high again.

Top module: `cd_change_det`

## Requirements
- R1: The input-port view `inport_o` reports a channel whose carrier is present as 0 and a channel whose carrier is absent as 1.
- R2: Channel A carrier detect is bit 0 and channel B carrier detect is bit 1 of both `inport_o` and `chg_o`.
- R3: While reset is held and just after it is released, `inport_o` is 2'b10 (A present, B absent), `chg_o` is 0 and `irq_o` is 0.
- R4: A level change on a channel's `cd_i` line, in either direction, updates that channel's `inport_o` bit and sets its `chg_o` bit on the third rising clock edge after the change, and not before.
- R5: `irq_o` is 1 exactly when the change register holds a nonzero value.
- R6: During a cycle with `rd_chg_i` high, `chg_o` presents the register's contents. From the next cycle the register is 0 and `irq_o` is 0, unless R7 applies.
- R7: A change that reaches the register on the same edge that completes a read is kept: after the read the register holds that channel's bit and `irq_o` is 1.
- R8: Without a read, change bits accumulate and hold. A second change on another channel adds its bit, and cycles with no change leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cd_i | input | 2 | Raw carrier-detect lines, 1 = carrier present, bit 0 = channel A |
| rd_chg_i | input | 1 | Host read strobe for the change register |
| inport_o | output | 2 | Inverted synchronised carrier view |
| chg_o | output | 2 | Change register contents (read data) |
| irq_o | output | 1 | Interrupt request, high while a change is latched |

## Verification
Directed patterns first move one channel at a time in each direction. This separates the bit positions and the inverted sense, and shows that both rising and falling carriers count as changes. The bench then moves a second channel before any read, to confirm that bits accumulate instead of being overwritten. It also samples one cycle early to pin the three-edge latency. A read timed onto the same edge as an arriving change separates a design that keeps the late event from one that wipes it. A seeded random sequence of level patterns with interleaved reads then compares every output against a bench model of the sticky register.

// File: rtl/cd_pkg.sv
package cd_pkg;

  // Port view: a present carrier reads as 0.
  function automatic logic [1:0] view_of(input logic [1:0] level);
    return ~level;
  endfunction

  // Bits whose level moved between two samples.
  function automatic logic [1:0] moved(input logic [1:0] now_s, input logic [1:0] was_s);
    return now_s ^ was_s;
  endfunction

  // Next change-register value: a read empties it, fresh events are always kept.
  function automatic logic [1:0] chg_next(input logic [1:0] cur,
                                          input logic [1:0] ev,
                                          input logic       rd);
    return (rd ? 2'b00 : cur) | ev;
  endfunction

endpackage

// File: rtl/cd_sync.sv
module cd_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/cd_edge.sv
module cd_edge #(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] ev_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= sync_i;
  end

  assign level_o = prev_q;
  assign ev_o    = sync_i ^ prev_q;

  // R4: an event is followed by the held level moving on those bits
  assert_event_moves_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_o != '0) |=> ((level_o ^ $past(level_o)) == $past(ev_o)));
endmodule

// File: rtl/cd_chg_reg.sv
module cd_chg_reg #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ev_i,
  input  logic         rd_i,
  output logic [W-1:0] chg_o,
  output logic         irq_o
);
  logic [W-1:0] chg_q;
  logic [W-1:0] chg_d;
  logic         irq_q;

  always_comb begin
    chg_d = (rd_i ? '0 : chg_q) | ev_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chg_q <= '0;
      irq_q <= 1'b0;
    end else begin
      chg_q <= chg_d;
      irq_q <= |chg_d;
    end
  end

  assign chg_o = chg_q;
  assign irq_o = irq_q;

  // R5: request tracks a nonempty register
  assert_irq_tracks_chg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (chg_o != '0));
  // R6: a read with no new event leaves the register empty
  assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && ev_i == '0) |=> (chg_o == '0 && !irq_o));
  // R7: an event is present in the register on the next cycle, read or not
  assert_event_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i != '0) |=> ((chg_o & $past(ev_i)) == $past(ev_i)));
  // R8: quiet cycles hold the register
  assert_hold_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && ev_i == '0) |=> $stable(chg_o));
endmodule

// File: rtl/cd_change_det.sv
module cd_change_det #(
  parameter int           NCH        = 2,
  parameter int           SYNC_DEPTH = 2,
  parameter logic [NCH-1:0] RST_LEVEL = 2'b01
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] cd_i,
  input  logic           rd_chg_i,
  output logic [NCH-1:0] inport_o,
  output logic [NCH-1:0] chg_o,
  output logic           irq_o
);
  logic [NCH-1:0] sync_w;
  logic [NCH-1:0] level_w;
  logic [NCH-1:0] ev_w;

  cd_sync #(.W(NCH), .STAGES(SYNC_DEPTH), .RST_VAL(RST_LEVEL)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cd_i),
    .q_o   (sync_w)
  );

  cd_edge #(.W(NCH), .RST_VAL(RST_LEVEL)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_w),
    .level_o(level_w),
    .ev_o   (ev_w)
  );

  cd_chg_reg #(.W(NCH)) u_chg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ev_i  (ev_w),
    .rd_i  (rd_chg_i),
    .chg_o (chg_o),
    .irq_o (irq_o)
  );

  assign inport_o = ~level_w;

  // R1: the port view and the change register move together on an event
  assert_view_follows_event_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_w != '0) |=> ((inport_o ^ $past(inport_o)) == $past(ev_w)));
endmodule

// File: tb/cd_change_det_tb.sv
module cd_change_det_tb_top;
  import cd_pkg::*;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic       clk;
  logic       rst_n;
  logic [1:0] cd;
  logic       rd;
  logic [1:0] inport;
  logic [1:0] chg;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [1:0] m_chg;
  logic [1:0] m_lvl;

  cd_change_det dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cd_i(cd), .rd_chg_i(rd),
    .inport_o(inport), .chg_o(chg), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive new levels at a negedge and wait out the three-edge latency.
  task automatic move(input logic [1:0] lvl);
    m_chg = m_chg | moved(lvl, m_lvl);
    m_lvl = lvl;
    cd = lvl;
    nclk(3);
    #1;
  endtask

  task automatic check_all(input string req);
    chk({req, " inport"}, 32'(inport), 32'(view_of(m_lvl)));
    chk({req, " chg"}, 32'(chg), 32'(m_chg));
    chk({req, " irq"}, 32'(irq), 32'(m_chg != 2'b00));
  endtask

  task automatic do_read(input string req);
    @(negedge clk);
    rd = 1'b1;
    #1;
    chk({req, " read data"}, 32'(chg), 32'(m_chg));
    @(negedge clk);
    rd = 1'b0;
    m_chg = chg_next(m_chg, 2'b00, 1'b1);
    #1;
    chk({req, " chg after read"}, 32'(chg), 32'(m_chg));
    chk({req, " irq after read"}, 32'(irq), 32'(m_chg != 2'b00));
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    cd    = 2'b01;
    rd    = 1'b0;
    m_chg = 2'b00;
    m_lvl = 2'b01;
    nclk(3);
    #1;
    // R3: reset state
    chk("R3 inport in reset", 32'(inport), 32'h2);
    chk("R3 chg in reset", 32'(chg), 32'h0);
    chk("R3 irq in reset", 32'(irq), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    nclk(4);
    #1;
    check_all("R3 after release");

    // R4 latency and R2/R1: channel B carrier arrives
    @(negedge clk);
    cd = 2'b11;
    nclk(2);
    #1;
    chk("R4 not before third edge chg", 32'(chg), 32'h0);
    chk("R4 not before third edge inport", 32'(inport), 32'h2);
    @(negedge clk);
    #1;
    m_chg = 2'b10;
    m_lvl = 2'b11;
    chk("R2 channel B bit 1 chg", 32'(chg), 32'h2);
    chk("R1 present reads 0", 32'(inport), 32'h0);
    chk("R5 irq raised", 32'(irq), 32'h1);

    // R6: read returns and clears
    do_read("R6");

    // R1/R2/R4: channel A carrier lost, falling direction
    @(negedge clk);
    move(2'b10);
    check_all("R2 channel A bit 0 falling R4");

    // R8: B lost without read, bits accumulate
    @(negedge clk);
    move(2'b00);
    check_all("R8 accumulate");
    nclk(5);
    #1;
    check_all("R8 hold quiet");
    do_read("R6 two bits");

    // R7: change arrives on the edge that completes the read
    @(negedge clk);
    move(2'b01);
    check_all("R7 setup");
    @(negedge clk);
    cd = 2'b11;
    @(negedge clk);
    @(negedge clk);
    rd = 1'b1;
    #1;
    chk("R7 read data old", 32'(chg), 32'h1);
    @(negedge clk);
    rd = 1'b0;
    m_lvl = 2'b11;
    m_chg = 2'b10;
    #1;
    chk("R7 late event kept", 32'(chg), 32'h2);
    chk("R7 irq after coincident read", 32'(irq), 32'h1);
    chk("R7 inport", 32'(inport), 32'h0);
    do_read("R7 drain");

    // Random sequence
    for (int k = 0; k < 300; k++) begin
      logic [1:0] nl;
      nl = 2'($urandom());
      @(negedge clk);
      move(nl);
      check_all("R4 random");
      if ($urandom_range(0, 2) == 0) do_read("R6 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule